// File: doc/BRIEF.md
# CIC Decimator with Pre-Attenuation Shifter

This block reduces the sample rate of a signed 24-bit stream by an integer ratio R using a cascade of N integrators followed by N comb sections. The CIC gain is R^N, and it grows very fast as R and N increase. To keep that gain from overflowing the word, each input sample is first sign-extended into the low end of a 69-bit word. It is then shifted up by a programmable 5-bit amount before it enters the first integrator.

Placing the sample at the bottom of the word is a fixed attenuation of 2^-45 relative to the top 24 bits. The shift restores a gain of 2^0 to 2^31. The pre-CIC gain can therefore be any of 32 powers of two from 2^-45 to 2^-14. A shift of 45 - ceil(log2(R^N)) keeps the total gain within [0.5, 1.0]. That shift is computed outside the block and supplied as a configuration input.

The output is the top 24 bits of the final comb result. It is presented with a one-cycle valid pulse once per R accepted input samples. The ratio, order and shift are captured only on reset or on a synchronous clear, and the clear also empties all filter state.

Top module: `cic_atten_decim`

## Requirements
- R1: After reset or clear, `out_vld` is 0 and `dout` is 0 until the first decimated output is produced.
- R2: Each accepted sample is sign-extended to 69 bits and multiplied by 2^`shift`. With order 0 this value passes straight through, so `dout` equals bits 68:45 of it. For shift 31 this is `din` arithmetically shifted right by 14, which leaves only 10 significant bits.
- R3: All integrator and comb arithmetic is two's-complement at 69 bits and wraps on overflow, and `dout` is bits 68:45 of the wrapped result.
- R4: `out_vld` pulses for one cycle in the cycle after every R-th accepted sample (`in_vld` high), counted from the last reset or clear. Cycles with `in_vld` low do not advance the count.
- R5: For a constant input c, with R^N a power of two and shift = 45 - log2(R^N), the output settles to exactly c after N+1 outputs.
- R6: The order field selects 0 to 5 stages, and values 6 and 7 act as 5. Integrators run at the input rate and combs, with a differential delay of 1, run at the output rate.
- R7: Changes to `dec_r`, `order` or `shift` have no effect until the next reset or clear.
- R8: A clear in the same cycle as an accepted sample wins. The sample is dropped, no output follows in the next cycle, and the decimation count restarts from zero.
- R9: `dout` holds its value in every cycle in which `out_vld` is low, except directly after a reset or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures the configuration |
| clr | input | 1 | Synchronous clear of filter state; also captures the configuration |
| in_vld | input | 1 | Input sample strobe |
| din | input | 24 | Signed input sample |
| dec_r | input | 12 | Decimation ratio R (1 to 4095) |
| order | input | 3 | Number of stages N (0 to 5; 6 and 7 act as 5) |
| shift | input | 5 | Pre-CIC left shift, 0 to 31 |
| out_vld | output | 1 | Decimated output strobe |
| dout | output | 24 | Signed decimated sample, top 24 bits of the 69-bit comb result |

## Verification
Two things can fall in the same cycle: a synchronous clear and an accepted sample. The decimation boundary, where the R-th sample also loads the combs, can coincide with them. The bench provokes this by asserting the clear together with `in_vld` partway through a decimation period. It then judges the result by requiring that no output pulse follows and that the next output appears only after a full R fresh samples. A behavioural 69-bit model, compared on every clock, covers the same moment under all the other configurations.

// File: rtl/cic_atten_decim.sv
module cic_atten_decim #(
  parameter int DW   = 24,
  parameter int WW   = 69,
  parameter int MAXN = 5,
  parameter int RW   = 12,
  parameter int SW   = 5,
  parameter int NW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_vld,
  input  logic [DW-1:0] din,
  input  logic [RW-1:0] dec_r,
  input  logic [NW-1:0] order,
  input  logic [SW-1:0] shift,
  output logic          out_vld,
  output logic [DW-1:0] dout
);
  localparam int EXT = WW - DW;

  logic [RW-1:0] cfg_r;
  logic [NW-1:0] cfg_n;
  logic [SW-1:0] cfg_sh;
  logic [RW-1:0] cnt;
  logic          flush;
  logic          hit;
  logic [WW-1:0] xs;

  assign flush = rst | clr;
  assign xs    = {{EXT{din[DW-1]}}, din} << cfg_sh;
  assign hit   = in_vld && (cnt == cfg_r - 1'b1);

  always_ff @(posedge clk) begin
    if (flush) begin
      cfg_r  <= dec_r;
      cfg_n  <= (int'(order) > MAXN) ? NW'(MAXN) : order;
      cfg_sh <= shift;
    end
  end

  always_ff @(posedge clk) begin
    if (flush)      cnt <= '0;
    else if (hit)   cnt <= '0;
    else if (in_vld) cnt <= cnt + 1'b1;
  end

  logic [WW-1:0] ich [0:MAXN];
  logic [WW-1:0] cch [0:MAXN];
  assign ich[0] = xs;
  assign cch[0] = ich[MAXN];

  for (genvar k = 0; k < MAXN; k++) begin : g_stage
    logic [WW-1:0] acc, prv, isum, cdif;
    logic          on;
    assign on   = k < int'(cfg_n);
    assign isum = acc + ich[k];
    assign cdif = cch[k] - prv;
    assign ich[k+1] = on ? isum : ich[k];
    assign cch[k+1] = on ? cdif : cch[k];

    always_ff @(posedge clk) begin
      if (flush) begin
        acc <= '0;
        prv <= '0;
      end else begin
        if (in_vld && on) acc <= isum;
        if (hit && on)    prv <= cch[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      out_vld <= 1'b0;
      dout    <= '0;
    end else begin
      out_vld <= hit;
      if (hit) dout <= cch[MAXN][WW-1 -: DW];
    end
  end

  p_out_after_in_r4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld) && !$past(clr));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst || clr)
    (cfg_r != '0) |-> (cnt < cfg_r));

  p_clear_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_vld && dout == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && !$past(clr) && !$past(rst)) |-> $stable(dout));

  p_order_cap_r6: assert property (@(posedge clk) disable iff (rst)
    int'(cfg_n) <= MAXN);

  p_bypass_r2: assert property (@(posedge clk) disable iff (rst || clr)
    (hit && cfg_n == '0) |=> dout == $past(xs[WW-1 -: DW]));
endmodule

// File: tb/sim_cic_atten_decim.sv
module sim_cic_atten_decim;
  localparam int CLK = 10;

  logic        clk = 0, rst = 1, clr = 0, in_vld = 0;
  logic [23:0] din = 0;
  logic [11:0] dec_r = 1;
  logic [2:0]  order = 0;
  logic [4:0]  shift = 0;
  logic        out_vld;
  logic [23:0] dout;

  int total = 0, bad = 0;
  string req = "R1";
  bit done = 0;

  cic_atten_decim u0 (.clk, .rst, .clr, .in_vld, .din, .dec_r, .order,
                      .shift, .out_vld, .dout);

  always #(CLK/2) clk = ~clk;

  logic [68:0] mi [5];
  logic [68:0] mp [5];
  logic [68:0] v, t;
  int m_r, m_n, m_sh, m_cnt;
  logic m_vld;
  logic [23:0] m_dout;

  always @(posedge clk) begin
    if (rst || clr) begin
      m_r = dec_r; m_n = (order > 5) ? 5 : order; m_sh = shift;
      for (int k = 0; k < 5; k++) begin mi[k] = 0; mp[k] = 0; end
      m_cnt = 0; m_vld = 0; m_dout = 0;
    end else begin
      m_vld = 0;
      if (in_vld) begin
        v = {{45{din[23]}}, din};
        v = v << m_sh;
        for (int k = 0; k < m_n; k++) begin mi[k] = mi[k] + v; v = mi[k]; end
        if (m_cnt == m_r - 1) begin
          m_cnt = 0;
          for (int k = 0; k < m_n; k++) begin t = v - mp[k]; mp[k] = v; v = t; end
          m_dout = v[68:45];
          m_vld = 1;
        end else m_cnt++;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    check({req, " vld"}, {31'd0, out_vld}, {31'd0, m_vld});
    check({req, " dout"}, {8'd0, dout}, {8'd0, m_dout});
  end

  task automatic send(bit vv, logic [23:0] x);
    in_vld = vv; din = x;
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic setup(int r, int n, int sh);
    dec_r = 12'(r); order = 3'(n); shift = 5'(sh);
    clr = 1;
    @(negedge clk);
    clr = 0;
  endtask

  task automatic run(int cnt, bit gaps);
    for (int i = 0; i < cnt; i++) begin
      send(gaps ? ($urandom % 3 != 0) : 1'b1, 24'($urandom));
    end
  endtask

  logic [23:0] xv;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset vld", {31'd0, out_vld}, 0);
    check("R1 reset dout", {8'd0, dout}, 0);

    req = "R2";
    setup(1, 0, 31);
    foreach (xv[i]) ;
    xv = 24'h800000; send(1, xv);
    check("R2 min", {8'd0, dout}, {8'd0, 24'($signed(xv) >>> 14)});
    xv = 24'h7fffff; send(1, xv);
    check("R2 max", {8'd0, dout}, {8'd0, 24'($signed(xv) >>> 14)});
    xv = 24'h123456; send(1, xv);
    check("R2 mid", {8'd0, dout}, {8'd0, 24'($signed(xv) >>> 14)});
    setup(1, 0, 0);
    send(1, 24'h900000);
    check("R2 shift0 neg", {8'd0, dout}, {8'd0, 24'hffffff});
    send(1, 24'h7fffff);
    check("R2 shift0 pos", {8'd0, dout}, 0);

    req = "R5";
    setup(16, 4, 29);
    for (int i = 0; i < 160; i++) send(1, 24'd12345);
    check("R5 dc gain", {8'd0, dout}, 32'd12345);
    setup(128, 2, 31);
    for (int i = 0; i < 512; i++) send(1, 24'hfff000);
    check("R5 dc neg", {8'd0, dout}, {8'd0, 24'hfff000});

    req = "R4";
    setup(128, 2, 31);
    run(1200, 1);
    setup(3, 1, 31);
    run(60, 1);

    req = "R6";
    setup(8, 7, 30);
    run(400, 0);
    setup(8, 5, 30);
    run(400, 1);
    setup(4, 3, 31);
    run(200, 1);

    req = "R3";
    setup(64, 5, 31);
    run(3000, 1);

    req = "R7";
    setup(1, 0, 31);
    shift = 0; order = 5; dec_r = 7;
    xv = 24'h654321; send(1, xv);
    check("R7 config held", {8'd0, dout}, {8'd0, 24'($signed(xv) >>> 14)});
    check("R7 ratio held", {31'd0, out_vld}, 1);

    req = "R8";
    setup(3, 0, 31);
    send(1, 24'h100000); send(1, 24'h200000);
    in_vld = 1; din = 24'h300000; clr = 1;
    @(negedge clk);
    clr = 0; in_vld = 0;
    check("R8 no output", {31'd0, out_vld}, 0);
    send(1, 24'h111111); send(1, 24'h222222);
    check("R8 count restart", {31'd0, out_vld}, 0);
    send(1, 24'h333333);
    check("R8 third sample out", {31'd0, out_vld}, 1);

    req = "R9";
    setup(5, 2, 31);
    run(100, 1);
    send(0, 24'h0);
    xv = dout;
    repeat (3) send(0, 24'h0);
    check("R9 hold", {8'd0, dout}, {8'd0, xv});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule